// File: doc/BRIEF.md
# Coherency-Port Read Burst Splitter

This block sits between an AXI read master with a 128-bit data bus and a coherency read port. The port only accepts two read shapes: one beat of 16 bytes aligned to 16 bytes, or four beats (64 bytes) aligned to 64 bytes. The master may ask for an INCR burst of any length from 1 to 256 beats at any address. The block accepts one such request and turns it into a sequence of legal reads that covers the same beats. It then returns the read data to the master as one unbroken burst.

Each issued read also has its sideband fields rewritten. For the cache and protection attributes, a bit mask chosen at build time picks, bit by bit, either a fixed override value or the master's own bit. The 2-bit shareability code on the port's user field comes from the master's user bits through one of seven selectable mappings. The master's ID is carried on every issued read, zero-extended to 5 bits, and is returned on every data beat.

Top module: `coh_rd_splitter`

## Requirements
- R1: Every issued read has size code 4 (16 bytes per beat) and burst type INCR (code 1). It is either `d_arlen`=3 with address bits [5:0] equal to zero, or `d_arlen`=0 with address bits [3:0] equal to zero.
- R2: The first issued address is the master's address with bits [3:0] cleared. A 4-beat read is issued when the current address has bits [5:4] equal to zero and at least 4 beats remain; otherwise a 1-beat read is issued. The address then advances by 64 or 16 bytes. Exactly `u_arlen`+1 beats are issued in total.
- R3: Each bit of `d_arcache` equals bit b of CACHE_VAL where bit b of CACHE_MASK is 1, and equals bit b of the master's cache field otherwise.
- R4: `d_arprot` is formed the same way from PROT_MASK and PROT_VAL.
- R5: `d_aruser` encodes shareability as 00 none, 01 inner, 10 outer, and 11 never appears. SHARE_TYPE selects how it is formed from user bits u1 and u0. Types 0, 1 and 2 force 00, 01 and 10. Type 3 gives 10 if u1 is set, otherwise 01 if u0 is set, otherwise 00. Type 4 maps u0 to 00 or 01. Type 5 maps u0 to 00 or 10. Type 6 maps u0 to 01 or 10.
- R6: Data and response of each beat reach the master unchanged and in issue order. `u_rid` equals the accepted ID, and `d_arid` is that ID zero-extended to 5 bits.
- R7: `u_rlast` is high only on beat number `u_arlen` (counting from 0) of the original burst. Last flags from intermediate reads are not passed on.
- R8: `u_arready` is high only when no burst is in progress. It is low from the cycle after acceptance until the final beat's handshake, and high again in the cycle after that.
- R9: Once `d_arvalid` is high, it and the issued address and length hold steady until `d_arready` is seen.
- R10: In reset and directly after it, `u_arready` is 1, and `d_arvalid` and `u_rvalid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| u_arid | input | ID_W | Master read ID |
| u_araddr | input | AW | Master start address |
| u_arlen | input | 8 | Master burst length minus one |
| u_arcache | input | 4 | Master cache attributes |
| u_arprot | input | 3 | Master protection attributes |
| u_aruser | input | USER_W | Master user bits |
| u_arvalid | input | 1 | Master request valid |
| u_arready | output | 1 | Request accepted |
| u_rid | output | ID_W | Returned ID |
| u_rdata | output | 128 | Returned data |
| u_rresp | output | 2 | Returned response |
| u_rlast | output | 1 | Final beat of the burst |
| u_rvalid | output | 1 | Return beat valid |
| u_rready | input | 1 | Master takes beat |
| d_arid | output | 5 | Issued read ID |
| d_araddr | output | 40 | Issued read address |
| d_arlen | output | 8 | Issued length minus one (0 or 3) |
| d_arsize | output | 3 | Issued beat size code |
| d_arburst | output | 2 | Issued burst type |
| d_arcache | output | 4 | Rewritten cache attributes |
| d_arprot | output | 3 | Rewritten protection attributes |
| d_aruser | output | 2 | Shareability code |
| d_arvalid | output | 1 | Issued read valid |
| d_arready | input | 1 | Port takes read |
| d_rid | input | 5 | Port return ID |
| d_rdata | input | 128 | Port return data |
| d_rresp | input | 2 | Port return response |
| d_rlast | input | 1 | Port last beat of one read |
| d_rvalid | input | 1 | Port return beat valid |
| d_rready | output | 1 | Block takes return beat |

## Verification
The first issued read is due one cycle after the master's request handshake, and each later one is due one cycle after the previous issue handshake. Return beats pass through in the same cycle they arrive, and `u_arready` rises one cycle after the final beat's handshake. The bench drives every input on the falling edge and samples one nanosecond later. At that point every valid/ready pair shows the values that the next rising edge will use, so each handshake is checked in the cycle it completes. Queue-based port modelling with random stalls moves these handshakes around in time while the expected addresses and data stay fixed by arithmetic.

// File: rtl/coh_rd_pkg.sv
package coh_rd_pkg;
  localparam int DN_ID_W     = 5;
  localparam int DN_ADDR_W   = 40;
  localparam int DATA_W      = 128;
  localparam int DN_LEN_W    = 8;
  localparam int CHUNK_BEATS = 4;

  typedef logic [1:0] share_t;
  localparam share_t SHR_NONE  = 2'b00;
  localparam share_t SHR_INNER = 2'b01;
  localparam share_t SHR_OUTER = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/coh_rd_sideband.sv
module coh_rd_sideband import coh_rd_pkg::*; #(
  parameter logic [3:0] CACHE_MASK = 4'h0,
  parameter logic [3:0] CACHE_VAL  = 4'hF,
  parameter logic [2:0] PROT_MASK  = 3'h0,
  parameter logic [2:0] PROT_VAL   = 3'h2,
  parameter int         SHARE_TYPE = 3,
  parameter int         USER_W     = 2
) (
  input  logic [3:0]        in_cache,
  input  logic [2:0]        in_prot,
  input  logic [USER_W-1:0] in_user,
  output logic [3:0]        out_cache,
  output logic [2:0]        out_prot,
  output share_t            out_share
);
  logic [1:0] usr2;

  generate
    if (USER_W >= 2) begin : g_user_wide
      assign usr2 = in_user[1:0];
    end else begin : g_user_narrow
      assign usr2 = {1'b0, in_user[0]};
    end
  endgenerate

  // per-bit override selection
  generate
    for (genvar b = 0; b < 4; b++) begin : g_cache_bit
      assign out_cache[b] = CACHE_MASK[b] ? CACHE_VAL[b] : in_cache[b];
    end
    for (genvar b = 0; b < 3; b++) begin : g_prot_bit
      assign out_prot[b] = PROT_MASK[b] ? PROT_VAL[b] : in_prot[b];
    end
  endgenerate

  // shareability mapping, one variant per build
  generate
    if (SHARE_TYPE == 0) begin : g_sh_none
      assign out_share = SHR_NONE;
    end else if (SHARE_TYPE == 1) begin : g_sh_inner
      assign out_share = SHR_INNER;
    end else if (SHARE_TYPE == 2) begin : g_sh_outer
      assign out_share = SHR_OUTER;
    end else if (SHARE_TYPE == 3) begin : g_sh_two_bit
      assign out_share = usr2[1] ? SHR_OUTER : (usr2[0] ? SHR_INNER : SHR_NONE);
    end else if (SHARE_TYPE == 4) begin : g_sh_none_inner
      assign out_share = usr2[0] ? SHR_INNER : SHR_NONE;
    end else if (SHARE_TYPE == 5) begin : g_sh_none_outer
      assign out_share = usr2[0] ? SHR_OUTER : SHR_NONE;
    end else begin : g_sh_inner_outer
      assign out_share = usr2[0] ? SHR_OUTER : SHR_INNER;
    end
  endgenerate
endmodule

// File: rtl/coh_rd_issue.sv
module coh_rd_issue import coh_rd_pkg::*; #(
  parameter int CNT_W = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic [DN_ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]     start_beats,
  input  logic                 burst_done,
  output logic                 idle,
  output logic                 dn_arvalid,
  input  logic                 dn_arready,
  output logic [DN_ADDR_W-1:0] dn_araddr,
  output logic [DN_LEN_W-1:0]  dn_arlen
);
  localparam logic [CNT_W-1:0]     STEP_BIG   = CNT_W'(CHUNK_BEATS);
  localparam logic [CNT_W-1:0]     STEP_ONE   = CNT_W'(1);
  localparam logic [DN_ADDR_W-1:0] BYTES_BIG  = DN_ADDR_W'(CHUNK_BEATS * 16);
  localparam logic [DN_ADDR_W-1:0] BYTES_ONE  = DN_ADDR_W'(16);

  ctl_state_e             state_q, state_d;
  logic [DN_ADDR_W-1:0]   addr_q, addr_d;
  logic [CNT_W-1:0]       rem_q, rem_d;
  logic                   use_big;
  logic [CNT_W-1:0]       step;
  logic                   state_en, path_en;

  assign use_big = (addr_q[5:4] == 2'b00) && (rem_q >= STEP_BIG);
  assign step    = use_big ? STEP_BIG : STEP_ONE;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_ISSUE;
          addr_d  = {start_addr[DN_ADDR_W-1:4], 4'b0000};
          rem_d   = start_beats;
        end
      end
      ST_ISSUE: begin
        if (dn_arready) begin
          addr_d = addr_q + (use_big ? BYTES_BIG : BYTES_ONE);
          rem_d  = rem_q - step;
          if (rem_q == step) state_d = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (burst_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign state_en = (state_d != state_q);
  assign path_en  = ((state_q == ST_IDLE) && accept) || ((state_q == ST_ISSUE) && dn_arready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (path_en) begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
    end
  end

  assign idle       = (state_q == ST_IDLE);
  assign dn_arvalid = (state_q == ST_ISSUE);
  assign dn_araddr  = addr_q;
  assign dn_arlen   = use_big ? DN_LEN_W'(CHUNK_BEATS - 1) : '0;

  // R1: only the two legal read shapes leave the block
  assert_legal_shape_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dn_arvalid |-> ((dn_arlen == 8'd3) && (dn_araddr[5:0] == 6'd0)) ||
                   ((dn_arlen == 8'd0) && (dn_araddr[3:0] == 4'd0)));

  // R9: request held steady while stalled
  assert_ar_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_arvalid && !dn_arready) |=> (dn_arvalid && $stable(dn_araddr) && $stable(dn_arlen)));
endmodule

// File: rtl/coh_rd_merge.sv
module coh_rd_merge import coh_rd_pkg::*; #(
  parameter int ID_W  = 4,
  parameter int CNT_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_beats,
  input  logic [ID_W-1:0]   load_id,
  output logic [ID_W-1:0]   held_id,
  output logic              burst_done,
  input  logic [DATA_W-1:0] dn_rdata,
  input  logic [1:0]        dn_rresp,
  input  logic              dn_rlast,
  input  logic              dn_rvalid,
  output logic              dn_rready,
  output logic [ID_W-1:0]   up_rid,
  output logic [DATA_W-1:0] up_rdata,
  output logic [1:0]        up_rresp,
  output logic              up_rlast,
  output logic              up_rvalid,
  input  logic              up_rready
);
  logic [CNT_W-1:0] left_q, left_d;
  logic [ID_W-1:0]  id_q;
  logic             active, fire, left_en;

  assign active = (left_q != '0);
  assign fire   = up_rvalid && up_rready;

  always_comb begin
    left_d = left_q;
    if (load)      left_d = load_beats;
    else if (fire) left_d = left_q - CNT_W'(1);
  end

  assign left_en = load || fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (left_en) begin
      left_q <= left_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q <= '0;
    end else if (load) begin
      id_q <= load_id;
    end
  end

  assign up_rvalid  = dn_rvalid && active;
  assign dn_rready  = up_rready && active;
  assign up_rlast   = (left_q == CNT_W'(1));
  assign up_rdata   = dn_rdata;
  assign up_rresp   = dn_rresp;
  assign up_rid     = id_q;
  assign held_id    = id_q;
  assign burst_done = fire && up_rlast;

  // R7: final upstream beat coincides with the end of a port read
  assert_final_on_port_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && up_rlast) |-> dn_rlast);

  // R7: no further beat is offered once the final one is taken
  assert_quiet_after_final_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && up_rlast) |=> !up_rvalid);
endmodule

// File: rtl/coh_rd_splitter.sv
module coh_rd_splitter import coh_rd_pkg::*; #(
  parameter int         ID_W       = 4,
  parameter int         AW         = 40,
  parameter int         USER_W     = 2,
  parameter int         LEN_W      = 8,
  parameter logic [3:0] CACHE_MASK = 4'h0,
  parameter logic [3:0] CACHE_VAL  = 4'hF,
  parameter logic [2:0] PROT_MASK  = 3'h0,
  parameter logic [2:0] PROT_VAL   = 3'h2,
  parameter int         SHARE_TYPE = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ID_W-1:0]    u_arid,
  input  logic [AW-1:0]      u_araddr,
  input  logic [LEN_W-1:0]   u_arlen,
  input  logic [3:0]         u_arcache,
  input  logic [2:0]         u_arprot,
  input  logic [USER_W-1:0]  u_aruser,
  input  logic               u_arvalid,
  output logic               u_arready,
  output logic [ID_W-1:0]    u_rid,
  output logic [127:0]       u_rdata,
  output logic [1:0]         u_rresp,
  output logic               u_rlast,
  output logic               u_rvalid,
  input  logic               u_rready,
  output logic [4:0]         d_arid,
  output logic [39:0]        d_araddr,
  output logic [7:0]         d_arlen,
  output logic [2:0]         d_arsize,
  output logic [1:0]         d_arburst,
  output logic [3:0]         d_arcache,
  output logic [2:0]         d_arprot,
  output logic [1:0]         d_aruser,
  output logic               d_arvalid,
  input  logic               d_arready,
  input  logic [4:0]         d_rid,
  input  logic [127:0]       d_rdata,
  input  logic [1:0]         d_rresp,
  input  logic               d_rlast,
  input  logic               d_rvalid,
  output logic               d_rready
);
  localparam int CNT_W = LEN_W + 1;

  logic                 accept, idle, burst_done;
  logic [CNT_W-1:0]     beats;
  logic [ID_W-1:0]      held_id;
  logic [3:0]           sb_cache, cache_q;
  logic [2:0]           sb_prot, prot_q;
  share_t               sb_share, share_q;

  assign u_arready = idle;
  assign accept    = u_arvalid && idle;
  assign beats     = {1'b0, u_arlen} + CNT_W'(1);

  coh_rd_sideband #(
    .CACHE_MASK (CACHE_MASK),
    .CACHE_VAL  (CACHE_VAL),
    .PROT_MASK  (PROT_MASK),
    .PROT_VAL   (PROT_VAL),
    .SHARE_TYPE (SHARE_TYPE),
    .USER_W     (USER_W)
  ) i_sideband (
    .in_cache  (u_arcache),
    .in_prot   (u_arprot),
    .in_user   (u_aruser),
    .out_cache (sb_cache),
    .out_prot  (sb_prot),
    .out_share (sb_share)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cache_q <= '0;
      prot_q  <= '0;
      share_q <= SHR_NONE;
    end else if (accept) begin
      cache_q <= sb_cache;
      prot_q  <= sb_prot;
      share_q <= sb_share;
    end
  end

  coh_rd_issue #(.CNT_W(CNT_W)) i_issue (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .start_addr  (DN_ADDR_W'(u_araddr)),
    .start_beats (beats),
    .burst_done  (burst_done),
    .idle        (idle),
    .dn_arvalid  (d_arvalid),
    .dn_arready  (d_arready),
    .dn_araddr   (d_araddr),
    .dn_arlen    (d_arlen)
  );

  coh_rd_merge #(.ID_W(ID_W), .CNT_W(CNT_W)) i_merge (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .load_beats (beats),
    .load_id    (u_arid),
    .held_id    (held_id),
    .burst_done (burst_done),
    .dn_rdata   (d_rdata),
    .dn_rresp   (d_rresp),
    .dn_rlast   (d_rlast),
    .dn_rvalid  (d_rvalid),
    .dn_rready  (d_rready),
    .up_rid     (u_rid),
    .up_rdata   (u_rdata),
    .up_rresp   (u_rresp),
    .up_rlast   (u_rlast),
    .up_rvalid  (u_rvalid),
    .up_rready  (u_rready)
  );

  assign d_arid    = DN_ID_W'(held_id);
  assign d_arsize  = 3'd4;
  assign d_arburst = 2'b01;
  assign d_arcache = cache_q;
  assign d_arprot  = prot_q;
  assign d_aruser  = share_q;

  // R5: reserved shareability code never issued
  assert_share_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    d_arvalid |-> (d_aruser != 2'b11));

  // R6: returning beats belong to the burst in progress
  assert_rid_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    u_rvalid |-> (d_rid == d_arid));

  // R8: busy right after acceptance, free right after the final beat
  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (u_arvalid && u_arready) |=> !u_arready);
  assert_free_after_final_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (u_rvalid && u_rready && u_rlast) |=> u_arready);
endmodule

// File: tb/test_coh_rd_splitter.sv
module test_coh_rd_splitter;
  import coh_rd_pkg::*;

  localparam logic [3:0] CM = 4'b1010;
  localparam logic [3:0] CV = 4'b0101;
  localparam logic [2:0] PM = 3'b101;
  localparam logic [2:0] PV = 3'b010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [3:0]   u_arid = '0;
  logic [39:0]  u_araddr = '0;
  logic [7:0]   u_arlen = '0;
  logic [3:0]   u_arcache = '0;
  logic [2:0]   u_arprot = '0;
  logic [1:0]   u_aruser = '0;
  logic         u_arvalid = 1'b0;
  logic         u_arready;
  logic [3:0]   u_rid;
  logic [127:0] u_rdata;
  logic [1:0]   u_rresp;
  logic         u_rlast, u_rvalid;
  logic         u_rready = 1'b0;
  logic [4:0]   d_arid;
  logic [39:0]  d_araddr;
  logic [7:0]   d_arlen;
  logic [2:0]   d_arsize;
  logic [1:0]   d_arburst;
  logic [3:0]   d_arcache;
  logic [2:0]   d_arprot;
  logic [1:0]   d_aruser;
  logic         d_arvalid;
  logic         d_arready = 1'b0;
  logic [4:0]   d_rid = '0;
  logic [127:0] d_rdata = '0;
  logic [1:0]   d_rresp = '0;
  logic         d_rlast = 1'b0;
  logic         d_rvalid = 1'b0;
  logic         d_rready;

  coh_rd_splitter #(
    .ID_W(4), .AW(40), .USER_W(2), .LEN_W(8),
    .CACHE_MASK(CM), .CACHE_VAL(CV), .PROT_MASK(PM), .PROT_VAL(PV), .SHARE_TYPE(3)
  ) i_coh_rd_splitter (
    .clk(clk), .rst_n(rst_n),
    .u_arid(u_arid), .u_araddr(u_araddr), .u_arlen(u_arlen), .u_arcache(u_arcache),
    .u_arprot(u_arprot), .u_aruser(u_aruser), .u_arvalid(u_arvalid), .u_arready(u_arready),
    .u_rid(u_rid), .u_rdata(u_rdata), .u_rresp(u_rresp), .u_rlast(u_rlast),
    .u_rvalid(u_rvalid), .u_rready(u_rready),
    .d_arid(d_arid), .d_araddr(d_araddr), .d_arlen(d_arlen), .d_arsize(d_arsize),
    .d_arburst(d_arburst), .d_arcache(d_arcache), .d_arprot(d_arprot), .d_aruser(d_aruser),
    .d_arvalid(d_arvalid), .d_arready(d_arready),
    .d_rid(d_rid), .d_rdata(d_rdata), .d_rresp(d_rresp), .d_rlast(d_rlast),
    .d_rvalid(d_rvalid), .d_rready(d_rready)
  );

  // all seven shareability variants, swept exhaustively
  logic [1:0] sb_user = '0;
  logic [1:0] sb_share [7];
  logic [3:0] sb_c [7];
  logic [2:0] sb_p [7];
  for (genvar k = 0; k < 7; k++) begin : g_sb
    coh_rd_sideband #(
      .CACHE_MASK(CM), .CACHE_VAL(CV), .PROT_MASK(PM), .PROT_VAL(PV),
      .SHARE_TYPE(k), .USER_W(2)
    ) i_sb (
      .in_cache(4'h0), .in_prot(3'h0), .in_user(sb_user),
      .out_cache(sb_c[k]), .out_prot(sb_p[k]), .out_share(sb_share[k])
    );
  end

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] fdat(input logic [39:0] a);
    return {a[31:0] ^ 32'hA5A5_0F0F, ~a[31:0], a[31:0] + 32'h0000_1234, {24'h0, a[39:32]}};
  endfunction

  function automatic logic [1:0] fresp(input logic [39:0] a);
    return a[5:4] ^ a[7:6];
  endfunction

  function automatic logic [1:0] share_map(input int t, input logic [1:0] u);
    case (t)
      0: return 2'b00;
      1: return 2'b01;
      2: return 2'b10;
      3: return u[1] ? 2'b10 : (u[0] ? 2'b01 : 2'b00);
      4: return u[0] ? 2'b01 : 2'b00;
      5: return u[0] ? 2'b10 : 2'b00;
      default: return u[0] ? 2'b10 : 2'b01;
    endcase
  endfunction

  // expectations for the burst in flight
  logic [39:0] ex_a0 = '0, ex_addr = '0;
  logic [8:0]  ex_rem = '0, ex_len = '0, rx_k = '0;
  logic [3:0]  ex_id = '0, ex_cache = '0;
  logic [2:0]  ex_prot = '0;
  logic [1:0]  ex_user = '0;

  // port model state
  logic [39:0] q_addr [64];
  logic [8:0]  q_len  [64];
  logic [4:0]  q_id   [64];
  logic [5:0]  q_wr = '0, q_rd = '0;
  logic [8:0]  q_beat = '0;
  logic        rv_hold = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic        fast = 1'b0;
  logic        prev_stall = 1'b0;
  logic [39:0] prev_addr = '0;
  logic [7:0]  prev_len = '0;

  always @(negedge clk) begin
    logic        big;
    logic [39:0] a;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rst_n) begin
      d_arready = fast | lfsr[0];
      u_rready  = fast | lfsr[5] | lfsr[7];
      if (!rv_hold && (q_wr != q_rd) && (fast || lfsr[3])) rv_hold = 1'b1;
      d_rvalid = rv_hold;
      if (rv_hold) begin
        a = q_addr[q_rd] + {27'd0, q_beat, 4'd0};
        d_rdata = fdat(a);
        d_rresp = fresp(a);
        d_rlast = (q_beat == q_len[q_rd]);
        d_rid   = q_id[q_rd];
      end
      #1;
      if (prev_stall) begin
        chk(d_arvalid && (d_araddr == prev_addr) && (d_arlen == prev_len), "R9 held request",
            128'({d_arvalid, d_araddr}), 128'({1'b1, prev_addr}));
      end
      prev_stall = d_arvalid && !d_arready;
      prev_addr  = d_araddr;
      prev_len   = d_arlen;
      if (d_arvalid && d_arready) begin
        big = (ex_addr[5:0] == 6'd0) && (ex_rem >= 9'd4);
        chk(((d_arlen == 8'd3) && (d_araddr[5:0] == 6'd0)) || ((d_arlen == 8'd0) && (d_araddr[3:0] == 4'd0)),
            "R1 shape", 128'({d_araddr, d_arlen}), 128'(0));
        chk((d_arsize == 3'd4) && (d_arburst == 2'b01), "R1 size/burst",
            128'({d_arsize, d_arburst}), 128'({3'd4, 2'b01}));
        chk(ex_rem != 9'd0, "R2 over-issue", 128'(ex_rem), 128'(1));
        chk((d_araddr == ex_addr) && (d_arlen == (big ? 8'd3 : 8'd0)), "R2 chunk",
            128'({d_araddr, d_arlen}), 128'({ex_addr, (big ? 8'd3 : 8'd0)}));
        chk(d_arcache == ((ex_cache & ~CM) | (CV & CM)), "R3 cache",
            128'(d_arcache), 128'((ex_cache & ~CM) | (CV & CM)));
        chk(d_arprot == ((ex_prot & ~PM) | (PV & PM)), "R4 prot",
            128'(d_arprot), 128'((ex_prot & ~PM) | (PV & PM)));
        chk(d_aruser == share_map(3, ex_user), "R5 share type 3",
            128'(d_aruser), 128'(share_map(3, ex_user)));
        chk(d_arid == {1'b0, ex_id}, "R6 arid", 128'(d_arid), 128'({1'b0, ex_id}));
        q_addr[q_wr] = d_araddr;
        q_len[q_wr]  = {1'b0, d_arlen};
        q_id[q_wr]   = d_arid;
        q_wr = q_wr + 6'd1;
        ex_addr = ex_addr + (big ? 40'd64 : 40'd16);
        ex_rem  = ex_rem - (big ? 9'd4 : 9'd1);
      end
      if (u_rvalid && u_rready) begin
        a = ex_a0 + {27'd0, rx_k, 4'd0};
        chk(u_rdata == fdat(a), "R6 data", u_rdata, fdat(a));
        chk(u_rresp == fresp(a), "R6 resp", 128'(u_rresp), 128'(fresp(a)));
        chk(u_rid == ex_id, "R6 rid", 128'(u_rid), 128'(ex_id));
        chk(u_rlast == (rx_k == ex_len), "R7 last", 128'(u_rlast), 128'(rx_k == ex_len));
        rx_k = rx_k + 9'd1;
      end
      if (d_rvalid && d_rready) begin
        rv_hold = 1'b0;
        if (q_beat == q_len[q_rd]) begin
          q_beat = '0;
          q_rd = q_rd + 6'd1;
        end else begin
          q_beat = q_beat + 9'd1;
        end
      end
    end
  end

  task automatic run_burst(input logic [39:0] a, input logic [7:0] len, input logic [3:0] id,
                           input logic [3:0] c, input logic [2:0] p, input logic [1:0] u);
    @(negedge clk);
    ex_a0 = {a[39:4], 4'h0};
    ex_addr = ex_a0;
    ex_rem = {1'b0, len} + 9'd1;
    ex_len = {1'b0, len};
    rx_k = '0;
    ex_id = id; ex_cache = c; ex_prot = p; ex_user = u;
    u_arid = id; u_araddr = a; u_arlen = len; u_arcache = c; u_arprot = p; u_aruser = u;
    u_arvalid = 1'b1;
    #2;
    while (!u_arready) begin
      @(negedge clk);
      #2;
    end
    @(negedge clk);
    u_arvalid = 1'b0;
    #2;
    chk(!u_arready, "R8 busy after accept", 128'(u_arready), 128'(0));
    while (rx_k <= ex_len) @(negedge clk);
    @(negedge clk);
    #2;
    chk(u_arready && !d_arvalid, "R8 free after final", 128'({u_arready, d_arvalid}), 128'(2));
    chk(ex_rem == 9'd0, "R2 total beats", 128'(ex_rem), 128'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk(u_arready && !d_arvalid && !u_rvalid, "R10 reset state",
        128'({u_arready, d_arvalid, u_rvalid}), 128'(4));
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    chk(u_arready && !d_arvalid && !u_rvalid, "R10 after reset",
        128'({u_arready, d_arvalid, u_rvalid}), 128'(4));

    for (int k = 0; k < 7; k++) begin
      for (int u = 0; u < 4; u++) begin
        sb_user = 2'(u);
        #1;
        chk(sb_share[k] == share_map(k, 2'(u)), $sformatf("R5 type %0d user %0d", k, u),
            128'(sb_share[k]), 128'(share_map(k, 2'(u))));
        chk(sb_share[k] != 2'b11, "R5 no reserved code", 128'(sb_share[k]), 128'(0));
      end
    end

    for (int s = 0; s < 8; s++) begin
      for (int l = 0; l < 10; l++) begin
        int n;
        n = s * 10 + l;
        fast = ((n % 3) == 0);
        run_burst(40'h0A_1234_5600 + 40'(s * 16) + ((s == 5) ? 40'h9 : 40'h0),
                  8'(l), 4'(n), 4'(n), 3'(n), 2'(n));
      end
    end
    fast = 1'b0;
    run_burst(40'h03_0000_0034, 8'd255, 4'hB, 4'h6, 3'h3, 2'b10);
    fast = 1'b1;
    run_burst(40'hFF_FFFF_FFC0, 8'd6, 4'h7, 4'hF, 3'h7, 2'b11);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule